// File: doc/BRIEF.md
# Hardware Trip and Breaker Interlock Sequencer

This block turns a set of fault flags into a protective action that needs no firmware. The flags are comparator overcurrent and overvoltage, gate-driver desaturation, a trip from the external protection panel, a rotor-side alarm and an emergency stop from the safety chain. Each flag passes through its own programmable blanking counter, so short switching spikes are ignored. A fault that survives blanking starts a fixed sequence. First the power-stage gates are blocked. Then the breaker or contactor is commanded open and the auxiliary contact is watched for confirmation. Finally an event carrying the trip source is reported.

The first qualified fault is stored as a binary source code and is held until the trip is cleared. If the auxiliary contact does not report "open" within a programmable number of cycles, the block raises a breaker-failure flag and keeps the gates blocked. A clear request returns the block to the armed state, but only once every fault input is inactive. A separate close-permission output is high only while the block is armed, the panel's block-close request is low and no fault input is active.

Top module: `trip_sequencer`

## Requirements
- R1: Fault bit i is qualified only after it has been sampled high on N consecutive clock edges, where N is the 4-bit field `blank_cfg[4i+3:4i]` (0 is treated as 1). A shorter pulse leaves `gate_block` low.
- R2: A low sample on a fault bit restarts its consecutive count from zero.
- R3: `gate_block` rises on the clock edge after a fault is qualified and stays high until a clear is accepted.
- R4: `brk_open` rises one clock after `gate_block` and stays high until a clear is accepted.
- R5: The source code is the lowest-indexed fault bit among those qualified when the block leaves the armed state. The bit order is 0 overcurrent, 1 overvoltage, 2 desaturation, 3 panel trip, 4 rotor alarm, 5 emergency stop. A later fault never changes the stored code before the clear.
- R6: Once `brk_open` is high, `aux_open` sampled high on a clock edge produces a one-cycle `evt_valid` pulse after that edge, with `evt_src` equal to the stored code.
- R7: If `aux_open` stays low for `tmo_cfg` edges after `brk_open` rises (0 treated as 1), `evt_fail` goes high together with `evt_valid`, and gates stay blocked. If `aux_open` is high on the expiry edge itself, it takes precedence and there is no failure.
- R8: `trip_clr` is acted on only after the report, and only on an edge where every `fault_in` bit is low. Otherwise it has no effect.
- R9: `close_permit` is high one clock after an edge at which the block was armed, `block_close` was low and every `fault_in` bit was low. Otherwise it is low.
- R10: A synchronous `rst` drives `gate_block`, `brk_open`, `evt_valid`, `evt_fail` and `close_permit` low and clears the stored source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_in | input | 6 | Raw fault flags, bit order as in R5 |
| blank_cfg | input | 24 | Per-bit blanking length, 4 bits per fault |
| tmo_cfg | input | 8 | Breaker feedback timeout in cycles |
| aux_open | input | 1 | Auxiliary contact reports breaker open |
| block_close | input | 1 | Panel request to forbid breaker closing |
| trip_clr | input | 1 | Request to clear a finished trip |
| gate_block | output | 1 | Block all power-stage gates |
| brk_open | output | 1 | Command breaker/contactor open |
| close_permit | output | 1 | Closing the breaker is allowed |
| evt_valid | output | 1 | One-cycle report pulse |
| evt_src | output | 3 | Stored trip source code |
| evt_fail | output | 1 | Breaker failed to open in time |
| status | output | 8 | {fail, source valid, source code, sequencer state} |

## Verification
Two functions can fall in the same cycle. The first case is expiry of the breaker-feedback timer and arrival of the auxiliary contact confirmation. The bench counts clock edges from the rise of `brk_open` and raises `aux_open` so that it is sampled on exactly the expiry edge. It then expects a clean report with no failure flag. The second case is two faults that qualify on the same edge. These are two single-cycle-blanked inputs raised together, and the lower index is expected as the source. A behavioural model steps alongside the design on every clock and judges all outputs in both cases.

// File: rtl/trip_pkg.sv
package trip_pkg;
  typedef enum logic [2:0] {
    ST_ARMED  = 3'd0,
    ST_BLOCK  = 3'd1,
    ST_OPEN   = 3'd2,
    ST_REPORT = 3'd3,
    ST_HOLD   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/trip_blank.sv
module trip_blank #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fault_i,
  input  logic [CW-1:0] len_i,
  output logic          qual_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] need_m1;

  // zero length behaves like one cycle
  always_comb need_m1 = (len_i == '0) ? '0 : len_i - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      qual_o <= 1'b0;
    end else begin
      qual_o <= fault_i && (cnt >= need_m1);
      if (!fault_i)         cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + CW'(1);
    end
  end

  assert_qual_needs_input_R1: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> $past(fault_i));
  assert_drop_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (!fault_i) |=> !qual_o);
endmodule

// File: rtl/trip_prio.sv
module trip_prio #(
  parameter int NF = 6,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture_i,
  input  logic          clear_i,
  input  logic [NF-1:0] qual_i,
  output logic [SW-1:0] src_o,
  output logic          valid_o
);
  logic [SW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (qual_i[i]) pick = SW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      src_o   <= '0;
      valid_o <= 1'b0;
    end else if (capture_i && !valid_o && (|qual_i)) begin
      src_o   <= pick;
      valid_o <= 1'b1;
    end
  end

  assert_src_held_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o)) |-> $stable(src_o));
endmodule

// File: rtl/trip_fsm.sv
module trip_fsm
  import trip_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_qual_i,
  input  logic          aux_open_i,
  input  logic          clr_i,
  input  logic          faults_idle_i,
  input  logic [TW-1:0] tmo_i,
  output seq_state_t    state_o,
  output logic          clear_o,
  output logic          gate_block_o,
  output logic          brk_open_o,
  output logic          evt_o,
  output logic          fail_o
);
  logic [TW-1:0] tmr;
  logic [TW-1:0] lim_m1;

  always_comb lim_m1 = (tmo_i == '0) ? '0 : tmo_i - TW'(1);
  always_comb clear_o = (state_o == ST_HOLD) && clr_i && faults_idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= ST_ARMED;
      tmr     <= '0;
      fail_o  <= 1'b0;
    end else begin
      unique case (state_o)
        ST_ARMED: if (any_qual_i) state_o <= ST_BLOCK;
        ST_BLOCK: begin
          state_o <= ST_OPEN;
          tmr     <= '0;
        end
        ST_OPEN: begin
          if (aux_open_i) begin
            state_o <= ST_REPORT;
          end else if (tmr == lim_m1) begin
            fail_o  <= 1'b1;
            state_o <= ST_REPORT;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_REPORT: state_o <= ST_HOLD;
        ST_HOLD: if (clear_o) begin
          state_o <= ST_ARMED;
          fail_o  <= 1'b0;
        end
        default: state_o <= ST_ARMED;
      endcase
    end
  end

  always_comb begin
    gate_block_o = (state_o != ST_ARMED);
    brk_open_o   = (state_o == ST_OPEN) || (state_o == ST_REPORT) || (state_o == ST_HOLD);
    evt_o        = (state_o == ST_REPORT);
  end

  assert_block_held_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_block_o && !clear_o) |=> gate_block_o);
  assert_open_after_block_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_open_o) |-> $past(gate_block_o));
  assert_evt_single_R6: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);
  assert_fail_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> gate_block_o);
  assert_clear_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_block_o) |-> $past(faults_idle_i));
endmodule

// File: rtl/trip_sequencer.sv
module trip_sequencer
  import trip_pkg::*;
#(
  parameter int NF = 6,
  parameter int CW = 4,
  parameter int TW = 8,
  localparam int SW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF-1:0]    fault_in,
  input  logic [NF*CW-1:0] blank_cfg,
  input  logic [TW-1:0]    tmo_cfg,
  input  logic             aux_open,
  input  logic             block_close,
  input  logic             trip_clr,
  output logic             gate_block,
  output logic             brk_open,
  output logic             close_permit,
  output logic             evt_valid,
  output logic [SW-1:0]    evt_src,
  output logic             evt_fail,
  output logic [SW+4:0]    status
);
  logic [NF-1:0] qual;
  logic          src_valid;
  logic          clear;
  seq_state_t    state;

  for (genvar g = 0; g < NF; g++) begin : g_blank
    trip_blank #(.CW(CW)) u_blank (
      .clk     (clk),
      .rst     (rst),
      .fault_i (fault_in[g]),
      .len_i   (blank_cfg[g*CW +: CW]),
      .qual_o  (qual[g])
    );
  end

  trip_prio #(.NF(NF), .SW(SW)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .capture_i (state == ST_ARMED),
    .clear_i   (clear),
    .qual_i    (qual),
    .src_o     (evt_src),
    .valid_o   (src_valid)
  );

  trip_fsm #(.TW(TW)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .any_qual_i    (|qual),
    .aux_open_i    (aux_open),
    .clr_i         (trip_clr),
    .faults_idle_i (fault_in == '0),
    .tmo_i         (tmo_cfg),
    .state_o       (state),
    .clear_o       (clear),
    .gate_block_o  (gate_block),
    .brk_open_o    (brk_open),
    .evt_o         (evt_valid),
    .fail_o        (evt_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) close_permit <= 1'b0;
    else     close_permit <= (state == ST_ARMED) && !block_close && (fault_in == '0);
  end

  assign status = {evt_fail, src_valid, evt_src, state};

  assert_permit_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    close_permit |-> (!$past(block_close) && ($past(fault_in) == '0)));
  assert_evt_has_src_R6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> src_valid);
endmodule

// File: tb/sim_trip_sequencer.sv
module sim_trip_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  fault_in = '0;
  logic [23:0] blank_cfg;
  logic [7:0]  tmo_cfg = 8'd6;
  logic        aux_open = 1'b0, block_close = 1'b0, trip_clr = 1'b0;
  logic        gate_block, brk_open, close_permit, evt_valid, evt_fail;
  logic [2:0]  evt_src;
  logic [7:0]  status;

  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trip_sequencer u0 (
    .clk(clk), .rst(rst), .fault_in(fault_in), .blank_cfg(blank_cfg), .tmo_cfg(tmo_cfg),
    .aux_open(aux_open), .block_close(block_close), .trip_clr(trip_clr),
    .gate_block(gate_block), .brk_open(brk_open), .close_permit(close_permit),
    .evt_valid(evt_valid), .evt_src(evt_src), .evt_fail(evt_fail), .status(status)
  );

  // blanking lengths: OC 4, OV 1, desat 3, panel 1, rotor 2, estop 1
  initial blank_cfg = {4'd1, 4'd2, 4'd1, 4'd3, 4'd1, 4'd4};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt[NF];
  bit m_q[NF];
  int m_ph, m_tmr, m_src;
  bit m_valid, m_fail, m_permit;

  function automatic int blen(int i);
    int v = int'(blank_cfg[i*4 +: 4]);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    bit nq[NF];
    bit idle_in;
    int lim;
    if (rst) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_q[i] = 0; end
      m_ph = 0; m_tmr = 0; m_src = 0; m_valid = 0; m_fail = 0; m_permit = 0;
    end else begin
      idle_in = (fault_in == 6'd0);
      for (int i = 0; i < NF; i++) begin
        nq[i] = fault_in[i] && (m_cnt[i] + 1 >= blen(i));
        m_cnt[i] = fault_in[i] ? ((m_cnt[i] < 15) ? m_cnt[i] + 1 : 15) : 0;
      end
      lim = (tmo_cfg == 0) ? 1 : int'(tmo_cfg);
      m_permit = (m_ph == 0) && !block_close && idle_in;
      case (m_ph)
        0: begin
          m_src = -1;
          for (int i = NF - 1; i >= 0; i--) if (m_q[i]) m_src = i;
          if (m_src >= 0) begin m_ph = 1; m_valid = 1; end else m_src = 0;
        end
        1: begin m_ph = 2; m_tmr = 0; end
        2: if (aux_open) m_ph = 3;
           else if (m_tmr == lim - 1) begin m_fail = 1; m_ph = 3; end
           else m_tmr++;
        3: m_ph = 4;
        default: if (trip_clr && idle_in) begin
          m_ph = 0; m_valid = 0; m_src = 0; m_fail = 0;
        end
      endcase
      for (int i = 0; i < NF; i++) m_q[i] = nq[i];
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(gate_block == (m_ph != 0), "R3 gate_block", gate_block, m_ph != 0);
      check(brk_open == (m_ph >= 2), "R4 brk_open", brk_open, m_ph >= 2);
      check(evt_valid == (m_ph == 3), "R6 evt_valid", evt_valid, m_ph == 3);
      if (m_valid) check(int'(evt_src) == m_src, "R5 evt_src", evt_src, m_src);
      check(evt_fail == m_fail, "R7 evt_fail", evt_fail, m_fail);
      check(close_permit == m_permit, "R9 close_permit", close_permit, m_permit);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_evt(output bit fail_seen, output int src_seen);
    while (!evt_valid) @(negedge clk);
    fail_seen = evt_fail;
    src_seen = int'(evt_src);
  endtask

  task automatic do_clear();
    trip_clr = 1'b1; tick(1); trip_clr = 1'b0; tick(2);
  endtask

  initial begin
    bit f; int s;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R10: state after reset
    check(!gate_block && !brk_open && !evt_valid && !evt_fail, "R10 reset outputs",
          {gate_block, brk_open, evt_valid, evt_fail}, 0);
    tick(1);
    check(close_permit, "R9 permit when armed", close_permit, 1);

    // R1: 3-cycle overcurrent pulse with blanking 4 is ignored
    fault_in[0] = 1'b1; tick(3); fault_in[0] = 1'b0; tick(4);
    check(!gate_block, "R1 short pulse ignored", gate_block, 0);

    // R2: 2 high, 1 low, 3 high never reaches 4 consecutive
    fault_in[0] = 1'b1; tick(2); fault_in[0] = 1'b0; tick(1);
    fault_in[0] = 1'b1; tick(3); fault_in[0] = 1'b0; tick(4);
    check(!gate_block, "R2 count restarts", gate_block, 0);

    // desaturation trip, later overvoltage must not replace source
    fault_in[2] = 1'b1; tick(3);
    fault_in[1] = 1'b1;
    while (!brk_open) @(negedge clk);
    check(gate_block, "R3 gates blocked before open", gate_block, 1);
    tick(2); aux_open = 1'b1;
    wait_evt(f, s);
    check(s == 2, "R5 first source kept", s, 2);
    check(!f, "R6 confirmed open no failure", f, 0);
    tick(1);
    check(!evt_valid, "R6 single pulse", evt_valid, 0);

    // R8: clear while faults active is ignored
    do_clear();
    check(gate_block, "R8 clear ignored with faults", gate_block, 1);
    fault_in = '0; tick(1);
    do_clear();
    check(!gate_block && !brk_open, "R8 clear accepted", gate_block, 0);
    tick(1);
    check(close_permit, "R9 permit after clear", close_permit, 1);

    // R9: block_close withdraws permission
    block_close = 1'b1; tick(2);
    check(!close_permit, "R9 block_close", close_permit, 1'b0);
    block_close = 1'b0; tick(2);

    // same-edge qualification of overvoltage and emergency stop
    fault_in[1] = 1'b1; fault_in[5] = 1'b1; tick(1);
    fault_in = '0;
    wait_evt(f, s);
    check(s == 1, "R5 lowest index wins", s, 1);
    tick(1); do_clear();

    // R7: breaker never confirms
    aux_open = 1'b0;
    fault_in[3] = 1'b1; tick(1); fault_in[3] = 1'b0;
    wait_evt(f, s);
    check(f, "R7 timeout failure", f, 1);
    check(s == 3, "R5 panel source", s, 3);
    tick(3);
    check(gate_block, "R7 gates held after failure", gate_block, 1);
    do_clear();
    check(!evt_fail, "R8 failure cleared", evt_fail, 0);

    // R7: confirmation on the expiry edge takes precedence
    fault_in[4] = 1'b1; tick(2); fault_in[4] = 1'b0;
    while (!brk_open) @(negedge clk);
    tick(int'(tmo_cfg) - 1);
    aux_open = 1'b1;
    wait_evt(f, s);
    check(!f, "R7 aux on expiry edge wins", f, 0);
    check(s == 4, "R5 rotor source", s, 4);
    tick(1); do_clear();
    tick(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule